// File: doc/BRIEF.md
# Flow-Control Calendar with Windowed Host Access

This block keeps a table of flow-control slots. Each slot holds a 2-bit control code and an 8-bit pipe or backpressure identifier. The table is split into groups of sixteen slots. The first slot of each group carries the link-level state. The other fifteen slots carry the state of one channel each. The table is cleared at reset to a stop state on the transmit side or a go state on the receive side, chosen by a parameter.

A host does not address single slots. It first loads a window register, which picks a group of eight slots and sets an optional auto-increment. It then reads or writes two data words, each holding four slots. With auto-increment set, a low-word write followed by a high-word write moves the window on by one, so the whole table can be loaded by repeating write pairs from window 0.

A scan port walks the table one slot per cycle while it is enabled and reports each slot's number, control code and identifier. A combinational channel port turns a channel number into the slot that holds it and returns that slot's contents.

Top module: `fc_calendar`

## Requirements
- R1: After reset every slot holds control code 3 (stop) when CLR_GO=0, or code 2 (go) when CLR_GO=1, with identifier 0. The window register is 0 with auto-increment off, and scan_vld is 0.
- R2: Data word 0 holds window slots 0..3 and data word 1 holds slots 4..7. Window slot k of a word sits at bits [10k+9:10k]: the control code is in the top 2 bits and the identifier in the low 8. The control codes are 0 = channel entry, 1 = link, 2 = go, 3 = stop.
- R3: A window-register write selects window w, which covers slots 8w..8w+7. A data write changes exactly the four slots of the selected word. rd_data always shows the selected word of the current window, and reading has no side effect.
- R4: With auto-increment set, a word-1 write that follows a word-0 write to the same window moves the window on by one. A word-1 write with no word-0 write before it, or any write with auto-increment off, leaves the window unchanged.
- R5: A word-0 write to an even window stores control code 1 in window slot 0, whatever the written value, while keeping the written identifier. Writes to odd windows store the written value unchanged.
- R6: When the window number is 36 or above, data writes change no slot, rd_data reads 0, and auto-increment does not move the window.
- R7: While scan_en is high, the scan port reports one slot per cycle, one cycle after the enabling edge, in ascending order, wrapping from slot 287 to 0. The pointer keeps its place while scan_en is low, and scan_vld is then 0.
- R8: Channel c (0..269) maps to slot 1 + c + floor(c/15). chan_ok is 1 and chan_ctl/chan_id show that slot. For c of 270 or above, chan_ok and the outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_wr | input | 1 | Load the window register |
| win_num | input | 6 | Window number to load |
| win_inc | input | 1 | Auto-increment setting to load |
| dat_wr | input | 1 | Write one data word of the current window |
| dat_sel | input | 1 | Word to write (0 = slots 0..3, 1 = slots 4..7) |
| dat_wdata | input | 40 | Write data, four 10-bit slots |
| rd_sel | input | 1 | Word to read |
| rd_data | output | 40 | Selected word of the current window |
| scan_en | input | 1 | Advance the scan one slot per cycle |
| scan_vld | output | 1 | Scan outputs valid |
| scan_slot | output | 9 | Slot number reported |
| scan_ctl | output | 2 | Control code of that slot |
| scan_id | output | 8 | Identifier of that slot |
| chan_in | input | 9 | Channel number to look up |
| chan_ok | output | 1 | Channel number is in range |
| chan_ctl | output | 2 | Control code of the channel's slot |
| chan_id | output | 8 | Identifier of the channel's slot |

## Verification
A window register that advances when it should not, or fails to advance, shows up on the very next read: rd_data then returns a neighbouring window's slots. A wrong slot address or a missed link override shows up at the next read of that window, or when the scan reaches that slot, which takes at most 288 cycles. The bench keeps its own copy of all slots and of the window state. It compares every read, every scanned slot and every channel lookup against that copy, so a lost or misplaced write shows up in the first comparison that covers it.

// File: rtl/fc_cal_pkg.sv
package fc_cal_pkg;

  typedef enum logic [1:0] {
    CTL_CHAN = 2'd0,
    CTL_LINK = 2'd1,
    CTL_GO   = 2'd2,
    CTL_STOP = 2'd3
  } fc_ctl_e;

  localparam int CTL_W = 2;

  // slot that holds channel c when every GROUP-th slot is a link slot
  function automatic int chan_slot(input int c, input int group);
    return 1 + c + c / (group - 1);
  endfunction

  // number of channel slots in a table of n slots
  function automatic int chan_count(input int n, input int group);
    return (n / group) * (group - 1);
  endfunction

  // value stored for one slot of a word write; even windows get a link slot 0
  function automatic logic [9:0] store_value(input logic [9:0] wval,
                                             input logic       even_win,
                                             input logic       first_slot);
    logic [9:0] v;
    v = wval;
    if (even_win && first_slot) v[9:8] = CTL_LINK;
    return v;
  endfunction

endpackage

// File: rtl/fc_cal_index.sv
module fc_cal_index #(
  parameter int NUM_WIN = 36,
  parameter int WIN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_wr,
  input  logic [WIN_W-1:0] win_num,
  input  logic             win_inc,
  input  logic             lo_wr,
  input  logic             hi_wr,
  output logic [WIN_W-1:0] win_q,
  output logic             win_ok,
  output logic             lo_acc,
  output logic             hi_acc,
  output logic             adv
);
  logic inc_q;
  logic pend_q;

  assign win_ok = (int'(win_q) < NUM_WIN);
  assign lo_acc = lo_wr && win_ok;
  assign hi_acc = hi_wr && win_ok;
  assign adv    = hi_acc && pend_q && inc_q && !win_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      inc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (win_wr) begin
      win_q  <= win_num;
      inc_q  <= win_inc;
      pend_q <= 1'b0;
    end else if (adv) begin
      win_q  <= win_q + 1'b1;
      pend_q <= 1'b0;
    end else if (hi_acc) begin
      pend_q <= 1'b0;
    end else if (lo_acc) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fc_cal_store.sv
module fc_cal_store #(
  parameter int   NUM_SLOTS  = 288,
  parameter int   WIN_SLOTS  = 8,
  parameter int   SLOT_W     = 10,
  parameter int   WIN_W      = 6,
  parameter int   SLOT_IW    = 9,
  parameter logic CLR_GO     = 1'b0,
  localparam int  WORD_SLOTS = WIN_SLOTS / 2,
  localparam int  WORD_W     = WORD_SLOTS * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_acc,
  input  logic               hi_acc,
  input  logic [WIN_W-1:0]   win,
  input  logic               win_ok,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               rd_sel,
  input  logic [SLOT_IW-1:0] scan_idx,
  input  logic [SLOT_IW-1:0] chan_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic [1:0]         slot0_ctl,
  output logic [SLOT_W-1:0]  scan_val,
  output logic [SLOT_W-1:0]  chan_val
);
  import fc_cal_pkg::*;

  localparam logic [SLOT_W-1:0] CLR_VAL =
    {(CLR_GO ? CTL_GO : CTL_STOP), {(SLOT_W-CTL_W){1'b0}}};

  logic [SLOT_W-1:0]  mem [NUM_SLOTS];
  logic [SLOT_IW-1:0] base;
  logic [SLOT_W-1:0]  wvals [WORD_SLOTS];

  assign base = win_ok ? SLOT_IW'(int'(win) * WIN_SLOTS) : '0;

  for (genvar k = 0; k < WORD_SLOTS; k++) begin : g_wval
    assign wvals[k] = store_value(wdata[k*SLOT_W +: SLOT_W],
                                  !win[0] && lo_acc, k == 0);
    assign rd_word[k*SLOT_W +: SLOT_W] =
      win_ok ? mem[int'(base) + (rd_sel ? WORD_SLOTS : 0) + k] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) mem[i] <= CLR_VAL;
    end else if (lo_acc || hi_acc) begin
      for (int k = 0; k < WORD_SLOTS; k++)
        mem[int'(base) + (hi_acc ? WORD_SLOTS : 0) + k] <= wvals[k];
    end
  end

  assign slot0_ctl = mem[base][SLOT_W-1 -: CTL_W];
  assign scan_val  = mem[scan_idx];
  assign chan_val  = mem[chan_idx];
endmodule

// File: rtl/fc_cal_scan.sv
module fc_cal_scan #(
  parameter int NUM_SLOTS = 288,
  parameter int SLOT_W    = 10,
  parameter int SLOT_IW   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic [SLOT_W-1:0]  ptr_val,
  output logic [SLOT_IW-1:0] ptr_q,
  output logic               vld_q,
  output logic [SLOT_IW-1:0] slot_q,
  output logic [SLOT_W-1:0]  val_q
);
  logic last;
  assign last = (int'(ptr_q) == NUM_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      vld_q  <= 1'b0;
      slot_q <= '0;
      val_q  <= '0;
    end else begin
      vld_q <= scan_en;
      if (scan_en) begin
        slot_q <= ptr_q;
        val_q  <= ptr_val;
        ptr_q  <= last ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_calendar.sv
module fc_calendar #(
  parameter int   NUM_SLOTS  = 288,
  parameter int   WIN_SLOTS  = 8,
  parameter int   GROUP      = 16,
  parameter int   ID_W       = 8,
  parameter logic CLR_GO     = 1'b0,
  localparam int  SLOT_W     = ID_W + fc_cal_pkg::CTL_W,
  localparam int  NUM_WIN    = NUM_SLOTS / WIN_SLOTS,
  localparam int  WIN_W      = $clog2(NUM_WIN),
  localparam int  SLOT_IW    = $clog2(NUM_SLOTS),
  localparam int  WORD_W     = (WIN_SLOTS / 2) * SLOT_W,
  localparam int  NUM_CHAN   = fc_cal_pkg::chan_count(NUM_SLOTS, GROUP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_wr,
  input  logic [WIN_W-1:0]   win_num,
  input  logic               win_inc,
  input  logic               dat_wr,
  input  logic               dat_sel,
  input  logic [WORD_W-1:0]  dat_wdata,
  input  logic               rd_sel,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               scan_en,
  output logic               scan_vld,
  output logic [SLOT_IW-1:0] scan_slot,
  output logic [1:0]         scan_ctl,
  output logic [ID_W-1:0]    scan_id,
  input  logic [SLOT_IW-1:0] chan_in,
  output logic               chan_ok,
  output logic [1:0]         chan_ctl,
  output logic [ID_W-1:0]    chan_id
);
  import fc_cal_pkg::*;

  logic [WIN_W-1:0]   win_q;
  logic               win_ok, lo_acc, hi_acc, adv;
  logic [1:0]         slot0_ctl;
  logic [SLOT_IW-1:0] scan_ptr, chan_idx;
  logic [SLOT_W-1:0]  scan_val, scan_q, chan_val;

  fc_cal_index #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_index (
    .clk(clk), .rst_n(rst_n),
    .win_wr(win_wr), .win_num(win_num), .win_inc(win_inc),
    .lo_wr(dat_wr && !dat_sel), .hi_wr(dat_wr && dat_sel),
    .win_q(win_q), .win_ok(win_ok),
    .lo_acc(lo_acc), .hi_acc(hi_acc), .adv(adv)
  );

  assign chan_ok  = (int'(chan_in) < NUM_CHAN);
  assign chan_idx = chan_ok ? SLOT_IW'(chan_slot(int'(chan_in), GROUP)) : '0;

  fc_cal_store #(
    .NUM_SLOTS(NUM_SLOTS), .WIN_SLOTS(WIN_SLOTS), .SLOT_W(SLOT_W),
    .WIN_W(WIN_W), .SLOT_IW(SLOT_IW), .CLR_GO(CLR_GO)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lo_acc(lo_acc), .hi_acc(hi_acc), .win(win_q), .win_ok(win_ok),
    .wdata(dat_wdata), .rd_sel(rd_sel),
    .scan_idx(scan_ptr), .chan_idx(chan_idx),
    .rd_word(rd_data), .slot0_ctl(slot0_ctl),
    .scan_val(scan_val), .chan_val(chan_val)
  );

  fc_cal_scan #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SLOT_IW(SLOT_IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .ptr_val(scan_val),
    .ptr_q(scan_ptr), .vld_q(scan_vld), .slot_q(scan_slot), .val_q(scan_q)
  );

  assign scan_ctl = scan_q[SLOT_W-1 -: CTL_W];
  assign scan_id  = scan_q[ID_W-1:0];
  assign chan_ctl = chan_ok ? chan_val[SLOT_W-1 -: CTL_W] : '0;
  assign chan_id  = chan_ok ? chan_val[ID_W-1:0] : '0;
endmodule

// File: rtl/fc_calendar_chk.sv
module fc_calendar_chk #(
  parameter int NUM_SLOTS = 288,
  parameter int GROUP     = 16,
  parameter int WIN_W     = 6,
  parameter int SLOT_IW   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               win_wr,
  input logic               scan_en,
  input logic               scan_vld,
  input logic [SLOT_IW-1:0] scan_slot,
  input logic               chan_ok,
  input logic [SLOT_IW-1:0] chan_idx,
  input logic [WIN_W-1:0]   win_q,
  input logic               win_ok,
  input logic               lo_acc,
  input logic               adv,
  input logic [1:0]         slot0_ctl
);
  // R4
  win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> win_q == $past(win_q) + 1'b1);

  // R6
  oob_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_ok && !win_wr) |=> !win_ok);

  // R5
  link_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_acc && !win_q[0] && !win_wr) |=> slot0_ctl == 2'd1);

  // R7
  scan_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> scan_vld);

  // R7
  scan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !scan_vld);

  // R7
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld && $past(scan_vld)) |->
      scan_slot == ((int'($past(scan_slot)) == NUM_SLOTS - 1) ? '0 : $past(scan_slot) + 1'b1));

  // R8
  chan_not_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_ok |-> (int'(chan_idx) % GROUP) != 0);
endmodule

bind fc_calendar fc_calendar_chk #(
  .NUM_SLOTS(NUM_SLOTS), .GROUP(GROUP), .WIN_W(WIN_W), .SLOT_IW(SLOT_IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .scan_en(scan_en),
  .scan_vld(scan_vld), .scan_slot(scan_slot), .chan_ok(chan_ok),
  .chan_idx(chan_idx), .win_q(win_q), .win_ok(win_ok), .lo_acc(lo_acc),
  .adv(adv), .slot0_ctl(slot0_ctl)
);

// File: tb/test_fc_calendar.sv
module test_fc_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 288;
  localparam int NW = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_wr = 1'b0;
  logic [5:0]  win_num = '0;
  logic        win_inc = 1'b0;
  logic        dat_wr = 1'b0;
  logic        dat_sel = 1'b0;
  logic [39:0] dat_wdata = '0;
  logic        rd_sel = 1'b0;
  logic [39:0] rd_data;
  logic        scan_en = 1'b0;
  logic        scan_vld;
  logic [8:0]  scan_slot;
  logic [1:0]  scan_ctl;
  logic [7:0]  scan_id;
  logic [8:0]  chan_in = '0;
  logic        chan_ok;
  logic [1:0]  chan_ctl;
  logic [7:0]  chan_id;

  fc_calendar i_fc_calendar (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_num(win_num),
    .win_inc(win_inc), .dat_wr(dat_wr), .dat_sel(dat_sel),
    .dat_wdata(dat_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .scan_en(scan_en), .scan_vld(scan_vld), .scan_slot(scan_slot),
    .scan_ctl(scan_ctl), .scan_id(scan_id), .chan_in(chan_in),
    .chan_ok(chan_ok), .chan_ctl(chan_ctl), .chan_id(chan_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  logic [9:0] mdl [NS];
  int  m_win;
  bit  m_inc;
  bit  m_pend;
  int  m_ptr;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_word(input bit sel);
    logic [39:0] w = '0;
    if (m_win < NW)
      for (int k = 0; k < 4; k++) w[k*10 +: 10] = mdl[m_win*8 + sel*4 + k];
    return w;
  endfunction

  function automatic int slot_of_chan(input int c);
    int grp = c / 15;
    return grp * 16 + (c % 15) + 1;
  endfunction

  task automatic set_win(input int w, input bit inc);
    @(negedge clk);
    win_wr = 1'b1; win_num = 6'(w); win_inc = inc;
    @(negedge clk);
    win_wr = 1'b0;
    m_win = w; m_inc = inc; m_pend = 1'b0;
  endtask

  task automatic write_word(input bit sel, input logic [39:0] d);
    @(negedge clk);
    dat_wr = 1'b1; dat_sel = sel; dat_wdata = d;
    @(negedge clk);
    dat_wr = 1'b0;
    if (m_win < NW) begin
      for (int k = 0; k < 4; k++) begin
        logic [9:0] v = d[k*10 +: 10];
        if (!sel && k == 0 && (m_win % 2 == 0)) v[9:8] = 2'd1;
        mdl[m_win*8 + sel*4 + k] = v;
      end
      if (sel) begin
        if (m_pend && m_inc) m_win++;
        m_pend = 1'b0;
      end else m_pend = 1'b1;
    end
  endtask

  task automatic read_chk(input bit sel, input string req);
    rd_sel = sel;
    #1;
    check(rd_data === exp_word(sel), req, 64'(rd_data), 64'(exp_word(sel)));
  endtask

  task automatic chan_chk(input int c, input string req);
    @(negedge clk);
    chan_in = 9'(c);
    #1;
    if (c < 270) begin
      logic [9:0] v = mdl[slot_of_chan(c)];
      check(chan_ok === 1'b1 && chan_ctl === v[9:8] && chan_id === v[7:0], req,
            64'({chan_ok, chan_ctl, chan_id}), 64'({1'b1, v}));
    end else
      check(chan_ok === 1'b0 && chan_ctl === 2'd0 && chan_id === 8'd0, req,
            64'({chan_ok, chan_ctl, chan_id}), 64'd0);
  endtask

  task automatic scan_run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      scan_en = 1'b1;
      @(negedge clk);
      check(scan_vld === 1'b1 && int'(scan_slot) == m_ptr &&
            {scan_ctl, scan_id} === mdl[m_ptr], req,
            64'({scan_vld, scan_slot, scan_ctl, scan_id}),
            64'({1'b1, 9'(m_ptr), mdl[m_ptr]}));
      m_ptr = (m_ptr == NS - 1) ? 0 : m_ptr + 1;
      scan_en = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4127));
    for (int i = 0; i < NS; i++) mdl[i] = 10'h300;
    m_win = 0; m_inc = 0; m_pend = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents and idle scan
    read_chk(0, "R1 reset word0");
    read_chk(1, "R1 reset word1");
    check(scan_vld === 1'b0, "R1 scan idle", 64'(scan_vld), 64'd0);

    // R4 bulk fill from window 0 with auto-increment
    set_win(0, 1'b1);
    for (int w = 0; w < NW; w++) begin
      write_word(0, {10'(w*8+3), 10'(w*8+2), 10'(w*8+1), 10'(10'h000 | w)});
      write_word(1, {10'h3c0 | 10'(w), 10'h280 | 10'(w), 10'h100 | 10'(w), 10'(w*8+4)});
    end
    read_chk(0, "R6 window 36 reads zero after fill");
    for (int w = 0; w < NW; w += 7) begin
      set_win(w, 1'b0);
      read_chk(0, "R4 R2 fill word0");
      read_chk(1, "R4 R2 fill word1");
    end

    // R5 even window forcing, odd window untouched
    set_win(4, 1'b0);
    write_word(0, {30'h0, 10'h0aa});
    read_chk(0, "R5 even window slot0 forced to link");
    set_win(5, 1'b0);
    write_word(0, {30'h0, 10'h3bb});
    read_chk(0, "R5 odd window slot0 kept");

    // R4 word1 alone, and no increment when off
    set_win(10, 1'b1);
    write_word(1, 40'h12345_6789a);
    read_chk(1, "R4 word1 alone no advance");
    set_win(11, 1'b0);
    write_word(0, 40'h0aaaa_55555);
    write_word(1, 40'h55555_aaaaa);
    read_chk(0, "R4 no increment when off");

    // R6 out-of-range window ignores writes
    set_win(40, 1'b1);
    write_word(0, 40'hfffff_fffff);
    write_word(1, 40'hfffff_fffff);
    read_chk(1, "R6 out of range reads zero");
    set_win(35, 1'b1);
    write_word(0, 40'h11111_22222);
    write_word(1, 40'h33333_44444);
    read_chk(0, "R6 increment to 36 reads zero");
    set_win(0, 1'b0);
    read_chk(0, "R6 window 0 not hit by ignored write");

    // R3 random mix of window loads, writes and reads
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom % 8);
      if (op == 0) set_win(int'($urandom % 40), 1'($urandom));
      else if (op < 5) write_word(1'($urandom), {$urandom, 8'($urandom)});
      else begin
        read_chk(1'($urandom), "R3 random read");
        read_chk(1'($urandom), "R3 repeated read no side effect");
      end
    end

    // R8 channel lookup
    chan_chk(0, "R8 channel 0");
    chan_chk(14, "R8 channel 14");
    chan_chk(15, "R8 channel 15");
    chan_chk(269, "R8 channel 269");
    chan_chk(270, "R8 channel 270 out of range");
    for (int i = 0; i < 20; i++) chan_chk(int'($urandom % 300), "R8 random channel");

    // R7 scan: full pass with wrap, then pause keeps position
    scan_run(NS + 5, "R7 scan order and wrap");
    @(negedge clk);
    check(scan_vld === 1'b0, "R7 paused scan", 64'(scan_vld), 64'd0);
    scan_run(3, "R7 resume after pause");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule